// File: doc/BRIEF.md
# Task Queue and Result FIFO

This block buffers mining work on the chip side. The host streams each task in as 48 bytes through a byte-write port. Once the final byte arrives, the task is committed to a bounded queue, and a core takes tasks from the head of that queue. Cores push finished results into a separate FIFO. Each result carries the task identifier, the reporting core, a completion flag and a nonce.

To collect results, the host first reads a one-byte status value that gives the number of pending results. It then reads exactly that many 8-byte records through the same byte-read port, each byte in a fixed position. A flush pulse discards every queued task and any task that is only partly written.

A core reports a finished nonce range with a result that has no nonce. Those reports are accepted only while the corresponding enable input is high. A task written into a full queue is lost and raises a sticky overflow flag. A result pushed into a full FIFO is lost.

Top module: `task_result_buffer`

## Requirements
- R1: After reset no task is offered to the cores, the overflow flag is low, the host read data is not valid, and the pending-result count reads 0.
- R2: Bytes written on the task port are gathered in order, 48 to a task. Byte k of a task appears on `core_task_data[8k+7:8k]`. `core_task_id` shows byte 0 as its upper half and byte 1 as its lower half (big-endian).
- R3: Committed tasks are offered to the cores in the order they were written. `core_task_valid` stays high while at least one task is queued, and each pop removes the head task.
- R4: The queue holds at most TASK_DEPTH (16) tasks. `task_full` is high while it holds that many. A task completed while the queue is full is discarded, and the queued tasks are left unchanged. That discard sets `task_ovf`, which stays high until a flush.
- R5: A flush pulse empties the task queue at once, throws away a partly written task so the next byte is byte 0 of a new task, and clears `task_ovf`.
- R6: A host read with `host_rd_sel`=0 returns, one cycle later with `host_rd_valid` high, the number of pending results, saturated at 255.
- R7: Host reads with `host_rd_sel`=1 drain results in push order, 8 bytes per result. Byte 0 is task id[15:8], byte 1 is task id[7:0], byte 2 is the core id, and byte 3 is {no-nonce flag, 7'b0}. Bytes 4 to 7 hold the nonce least significant byte first. The result leaves the FIFO after its byte 7 is read.
- R8: A result whose no-nonce flag is set is accepted only while `nononce_en` is high. Otherwise it is discarded and the pending count does not change.
- R9: The result FIFO holds RES_DEPTH (16) results. A push while it is full is discarded, the count stays at 16, and the stored results are left unchanged.
- R10: A result read while the FIFO is empty returns 8'hFF and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| task_wr_valid | input | 1 | Task byte strobe |
| task_wr_byte | input | 8 | Task byte |
| task_flush | input | 1 | Empty the task queue |
| core_task_pop | input | 1 | Core takes the head task |
| core_task_valid | output | 1 | A task is queued |
| core_task_id | output | 16 | Head task identifier |
| core_task_data | output | 384 | Head task, byte k at bits 8k+7:8k |
| task_full | output | 1 | Task queue full |
| task_ovf | output | 1 | Sticky task overflow |
| res_push | input | 1 | Core pushes a result |
| res_task_id | input | 16 | Result task identifier |
| res_core_id | input | 8 | Reporting core |
| res_no_nonce | input | 1 | Range finished, no nonce |
| res_nonce | input | 32 | Found nonce |
| nononce_en | input | 1 | Accept no-nonce reports |
| host_rd_req | input | 1 | Host byte read strobe |
| host_rd_sel | input | 1 | 0 status, 1 result data |
| host_rd_data | output | 8 | Read byte |
| host_rd_valid | output | 1 | Read byte valid |

## Verification
Result handling is first exercised with a table of records that vary the task id, the core id, the flag and the nonce. Draining them in full shows whether the bytes are in the right positions and the records come out in the right order. Tasks are written with a different value in every byte, so a swapped or shifted byte shows up, and they are popped back to confirm the queue order. Separate directed runs fill each buffer past its depth, flush during a partly written task, send no-nonce reports with the enable low and high, and read from an empty FIFO. These runs show whether extra or disabled entries are really discarded and leave the stored entries unchanged.

// File: rtl/tqrf_pkg.sv
package tqrf_pkg;
  localparam int TASK_BYTES = 48;
  localparam int RES_BYTES  = 8;

  typedef struct packed {
    logic [15:0] task_id;
    logic [7:0]  core_id;
    logic        no_nonce;
    logic [31:0] nonce;
  } res_entry_t;

  function automatic logic [7:0] res_byte(res_entry_t e, logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0:    b = e.task_id[15:8];
      3'd1:    b = e.task_id[7:0];
      3'd2:    b = e.core_id;
      3'd3:    b = {e.no_nonce, 7'b0};
      3'd4:    b = e.nonce[7:0];
      3'd5:    b = e.nonce[15:8];
      3'd6:    b = e.nonce[23:16];
      default: b = e.nonce[31:24];
    endcase
    return b;
  endfunction
endpackage

// File: rtl/tq_task_store.sv
module tq_task_store #(
  parameter int DEPTH = 16,
  parameter int BYTES = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  input  logic [7:0]         wr_byte,
  input  logic               flush,
  input  logic               pop,
  output logic               head_valid,
  output logic [BYTES*8-1:0] head_data,
  output logic               full,
  output logic               ovf
);
  localparam int W  = BYTES * 8;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int BW = $clog2(BYTES);

  logic [W-1:0]  mem_q [DEPTH];
  logic [W-1:0]  asm_q, asm_d;
  logic [BW-1:0] bcnt_q, bcnt_d;
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          last_byte, commit, accept, drop, do_pop;

  function automatic logic [PW-1:0] ptr_inc(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full       = (cnt_q == CW'(DEPTH));
  assign head_valid = (cnt_q != '0);
  assign head_data  = mem_q[rp_q];
  assign ovf        = ovf_q;

  assign last_byte = wr_valid && (bcnt_q == BW'(BYTES - 1));
  assign commit    = last_byte && !flush;
  assign accept    = commit && !full;
  assign drop      = commit && full;
  assign do_pop    = pop && head_valid && !flush;

  always_comb begin
    asm_d  = asm_q;
    bcnt_d = bcnt_q;
    if (wr_valid) begin
      asm_d[bcnt_q*8 +: 8] = wr_byte;
      bcnt_d = last_byte ? '0 : bcnt_q + 1'b1;
    end
    if (flush) bcnt_d = '0;
  end

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
      ovf_d = 1'b0;
    end else begin
      if (accept) wp_d = ptr_inc(wp_q);
      if (do_pop) rp_d = ptr_inc(rp_q);
      if (accept && !do_pop)      cnt_d = cnt_q + 1'b1;
      else if (!accept && do_pop) cnt_d = cnt_q - 1'b1;
      if (drop) ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asm_q  <= '0;
      bcnt_q <= '0;
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      asm_q  <= asm_d;
      bcnt_q <= bcnt_d;
      wp_q   <= wp_d;
      rp_q   <= rp_d;
      cnt_q  <= cnt_d;
      ovf_q  <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem_q[wp_q] <= asm_d;
  end

  // R4
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R4
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && bcnt_q == BW'(BYTES - 1) && full && !flush) |=> ovf);

  // R5
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!head_valid && !ovf));
endmodule

// File: rtl/tq_result_fifo.sv
module tq_result_fifo
  import tqrf_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  res_entry_t push_entry,
  input  logic       nononce_en,
  input  logic       rd_pop,
  output logic [7:0] rd_byte,
  output logic [7:0] level
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  res_entry_t    mem_q [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]    bsel_q, bsel_d;
  logic          full, accept, take, entry_done;
  logic [31:0]   cnt_wide;

  function automatic logic [PW-1:0] ptr_inc(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full       = (cnt_q == CW'(DEPTH));
  assign accept     = push && !full && (!push_entry.no_nonce || nononce_en);
  assign take       = rd_pop && (cnt_q != '0);
  assign entry_done = take && (bsel_q == 3'd7);
  assign rd_byte    = (cnt_q != '0) ? res_byte(mem_q[rp_q], bsel_q) : 8'hFF;
  assign cnt_wide   = 32'(cnt_q);
  assign level      = (cnt_wide > 32'd255) ? 8'hFF : cnt_wide[7:0];

  always_comb begin
    wp_d   = wp_q;
    rp_d   = rp_q;
    cnt_d  = cnt_q;
    bsel_d = bsel_q;
    if (accept) wp_d = ptr_inc(wp_q);
    if (take) bsel_d = bsel_q + 3'd1;
    if (entry_done) rp_d = ptr_inc(rp_q);
    if (accept && !entry_done)      cnt_d = cnt_q + 1'b1;
    else if (!accept && entry_done) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      bsel_q <= '0;
    end else begin
      wp_q   <= wp_d;
      rp_q   <= rp_d;
      cnt_q  <= cnt_d;
      bsel_q <= bsel_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem_q[wp_q] <= push_entry;
  end

  // R9
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !rd_pop) |=> $stable(level));

  // R8
  nononce_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && push_entry.no_nonce && !nononce_en && !rd_pop) |=> $stable(level));

  // R9
  res_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/task_result_buffer.sv
module task_result_buffer
  import tqrf_pkg::*;
#(
  parameter int TASK_DEPTH = 16,
  parameter int RES_DEPTH  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    task_wr_valid,
  input  logic [7:0]              task_wr_byte,
  input  logic                    task_flush,
  input  logic                    core_task_pop,
  output logic                    core_task_valid,
  output logic [15:0]             core_task_id,
  output logic [TASK_BYTES*8-1:0] core_task_data,
  output logic                    task_full,
  output logic                    task_ovf,
  input  logic                    res_push,
  input  logic [15:0]             res_task_id,
  input  logic [7:0]              res_core_id,
  input  logic                    res_no_nonce,
  input  logic [31:0]             res_nonce,
  input  logic                    nononce_en,
  input  logic                    host_rd_req,
  input  logic                    host_rd_sel,
  output logic [7:0]              host_rd_data,
  output logic                    host_rd_valid
);
  res_entry_t push_entry;
  logic [7:0] res_rd_byte, res_level, rd_data_d, rd_data_q;
  logic       rd_valid_q;

  assign push_entry = '{task_id: res_task_id, core_id: res_core_id,
                        no_nonce: res_no_nonce, nonce: res_nonce};

  tq_task_store #(.DEPTH(TASK_DEPTH), .BYTES(TASK_BYTES)) u_tasks (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (task_wr_valid),
    .wr_byte    (task_wr_byte),
    .flush      (task_flush),
    .pop        (core_task_pop),
    .head_valid (core_task_valid),
    .head_data  (core_task_data),
    .full       (task_full),
    .ovf        (task_ovf)
  );

  assign core_task_id = {core_task_data[7:0], core_task_data[15:8]};

  tq_result_fifo #(.DEPTH(RES_DEPTH)) u_results (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (res_push),
    .push_entry (push_entry),
    .nononce_en (nononce_en),
    .rd_pop     (host_rd_req && host_rd_sel),
    .rd_byte    (res_rd_byte),
    .level      (res_level)
  );

  always_comb rd_data_d = host_rd_sel ? res_rd_byte : res_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= host_rd_req;
      if (host_rd_req) rd_data_q <= rd_data_d;
    end
  end

  assign host_rd_data  = rd_data_q;
  assign host_rd_valid = rd_valid_q;

  // R10
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_req && host_rd_sel && res_level == 8'd0) |=> (host_rd_data == 8'hFF));

  // R6
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_req |=> host_rd_valid);
endmodule

// File: tb/tb_task_result_buffer.sv
module tb_task_result_buffer;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         task_wr_valid, task_flush, core_task_pop;
  logic [7:0]   task_wr_byte;
  logic         core_task_valid, task_full, task_ovf;
  logic [15:0]  core_task_id;
  logic [383:0] core_task_data;
  logic         res_push, res_no_nonce, nononce_en;
  logic [15:0]  res_task_id;
  logic [7:0]   res_core_id;
  logic [31:0]  res_nonce;
  logic         host_rd_req, host_rd_sel, host_rd_valid;
  logic [7:0]   host_rd_data;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  task_result_buffer dut (
    .clk(clk), .rst_n(rst_n),
    .task_wr_valid(task_wr_valid), .task_wr_byte(task_wr_byte),
    .task_flush(task_flush), .core_task_pop(core_task_pop),
    .core_task_valid(core_task_valid), .core_task_id(core_task_id),
    .core_task_data(core_task_data), .task_full(task_full), .task_ovf(task_ovf),
    .res_push(res_push), .res_task_id(res_task_id), .res_core_id(res_core_id),
    .res_no_nonce(res_no_nonce), .res_nonce(res_nonce), .nononce_en(nononce_en),
    .host_rd_req(host_rd_req), .host_rd_sel(host_rd_sel),
    .host_rd_data(host_rd_data), .host_rd_valid(host_rd_valid)
  );

  // record = {task id 16, core id 8, no-nonce 1, nonce 32}
  localparam logic [56:0] RVEC [0:5] = '{
    {16'hBEEF, 8'd3,   1'b0, 32'h12345678},
    {16'h0001, 8'd0,   1'b1, 32'h00000000},
    {16'hA55A, 8'd31,  1'b0, 32'hFFFFFFFE},
    {16'h8000, 8'd7,   1'b0, 32'h80000001},
    {16'h00FF, 8'd255, 1'b1, 32'hDEADBEEF},
    {16'h1234, 8'd16,  1'b0, 32'h0F1E2D3C}
  };

  function automatic logic [7:0] tb_byte(int t, int k);
    if (k == 0) return 8'(8'h12 + t);
    if (k == 1) return 8'(8'h34 ^ t);
    if (k < 4)  return 8'h00;
    return 8'((t * 29 + k * 3 + 1) & 255);
  endfunction

  function automatic logic [383:0] exp_task(int t);
    logic [383:0] v;
    for (int k = 0; k < 48; k++) v[k*8 +: 8] = tb_byte(t, k);
    return v;
  endfunction

  function automatic logic [7:0] exp_rbyte(logic [56:0] r, int i);
    case (i)
      0: return r[56:49];
      1: return r[48:41];
      2: return r[40:33];
      3: return {r[32], 7'b0};
      4: return r[7:0];
      5: return r[15:8];
      6: return r[23:16];
      default: return r[31:24];
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [383:0] act, logic [383:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_task(int t, int nbytes);
    for (int k = 0; k < nbytes; k++) begin
      task_wr_valid = 1'b1;
      task_wr_byte  = tb_byte(t, k);
      @(negedge clk);
    end
    task_wr_valid = 1'b0;
  endtask

  task automatic pop_task();
    core_task_pop = 1'b1;
    @(negedge clk);
    core_task_pop = 1'b0;
  endtask

  task automatic host_read(bit sel, output logic [7:0] b);
    host_rd_req = 1'b1;
    host_rd_sel = sel;
    @(negedge clk);
    host_rd_req = 1'b0;
    b = host_rd_data;
  endtask

  task automatic push_res(logic [56:0] r);
    res_push     = 1'b1;
    res_task_id  = r[56:41];
    res_core_id  = r[40:33];
    res_no_nonce = r[32];
    res_nonce    = r[31:0];
    @(negedge clk);
    res_push = 1'b0;
  endtask

  task automatic drain_check(logic [56:0] r, string req);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) begin
      host_read(1'b1, b);
      check(b == exp_rbyte(r, i), req, 384'(b), 384'(exp_rbyte(r, i)));
    end
  endtask

  task automatic status_check(int expn, string req);
    logic [7:0] b;
    host_read(1'b0, b);
    check(b == 8'(expn) && host_rd_valid, req, 384'(b), 384'(expn));
  endtask

  function automatic logic [56:0] fill_rec(int i);
    return {16'(16'h0100 + i), 8'(i), 1'b0, 32'(i * 32'h01010101)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    rst_n = 1'b0;
    task_wr_valid = 1'b0; task_wr_byte = '0; task_flush = 1'b0; core_task_pop = 1'b0;
    res_push = 1'b0; res_task_id = '0; res_core_id = '0; res_no_nonce = 1'b0;
    res_nonce = '0; nononce_en = 1'b1; host_rd_req = 1'b0; host_rd_sel = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!core_task_valid && !task_ovf && !host_rd_valid && !task_full, "R1",
          384'({core_task_valid, task_ovf, host_rd_valid}), 384'(0));
    rst_n = 1'b1;
    @(negedge clk);
    status_check(0, "R1");

    // table walk: R6 count, R7 byte layout and order
    foreach (RVEC[i]) push_res(RVEC[i]);
    status_check(6, "R6");
    foreach (RVEC[i]) drain_check(RVEC[i], "R7");
    status_check(0, "R7");

    // R2 assembly, R3 order
    write_task(0, 48);
    write_task(1, 48);
    write_task(2, 48);
    check(core_task_valid && core_task_data == exp_task(0), "R2", core_task_data, exp_task(0));
    check(core_task_id == {tb_byte(0, 0), tb_byte(0, 1)}, "R2",
          384'(core_task_id), 384'({tb_byte(0, 0), tb_byte(0, 1)}));
    pop_task();
    check(core_task_data == exp_task(1), "R3", core_task_data, exp_task(1));
    pop_task();
    check(core_task_data == exp_task(2), "R3", core_task_data, exp_task(2));
    pop_task();
    check(!core_task_valid, "R3", 384'(core_task_valid), 384'(0));

    // R4 bound and overflow
    for (int t = 10; t < 26; t++) write_task(t, 48);
    check(task_full && !task_ovf, "R4", 384'({task_full, task_ovf}), 384'(2'b10));
    write_task(26, 48);
    check(task_ovf && task_full, "R4", 384'({task_full, task_ovf}), 384'(2'b11));
    for (int t = 10; t < 26; t++) begin
      check(core_task_valid && core_task_data == exp_task(t), "R4", core_task_data, exp_task(t));
      pop_task();
    end
    check(!core_task_valid && task_ovf, "R4", 384'({core_task_valid, task_ovf}), 384'(2'b01));

    // R5 flush
    write_task(30, 48);
    write_task(31, 48);
    write_task(32, 10);
    task_flush = 1'b1;
    @(negedge clk);
    task_flush = 1'b0;
    check(!core_task_valid && !task_ovf, "R5", 384'({core_task_valid, task_ovf}), 384'(0));
    write_task(33, 48);
    check(core_task_valid && core_task_data == exp_task(33), "R5", core_task_data, exp_task(33));
    pop_task();

    // R8 no-nonce gating
    nononce_en = 1'b0;
    push_res({16'h7777, 8'd1, 1'b1, 32'h0});
    status_check(0, "R8");
    push_res({16'h6666, 8'd2, 1'b0, 32'h11223344});
    nononce_en = 1'b1;
    push_res({16'h5555, 8'd3, 1'b1, 32'h0});
    status_check(2, "R8");
    drain_check({16'h6666, 8'd2, 1'b0, 32'h11223344}, "R8");
    drain_check({16'h5555, 8'd3, 1'b1, 32'h0}, "R8");

    // R9 full result FIFO
    for (int i = 0; i < 18; i++) push_res(fill_rec(i));
    status_check(16, "R9");
    for (int i = 0; i < 16; i++) drain_check(fill_rec(i), "R9");
    status_check(0, "R9");

    // R10 empty read
    host_read(1'b1, b);
    check(b == 8'hFF, "R10", 384'(b), 384'hFF);
    status_check(0, "R10");
    push_res(RVEC[0]);
    drain_check(RVEC[0], "R10");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule